// File: doc/BRIEF.md
# System MMU Control and Fault Register Block

This block is the software-visible control surface of a system MMU. Software reaches it over a simple 32-bit register bus. Through it, software switches address translation on or off and halts translation traffic. It also loads the page-table base, kills TLB entries, and reads the type and address of any translation fault. The translation datapath (TLB and table walker) sits beside the block. It takes from the block an enable level, a hold level that stalls new traffic, one-cycle flush strobes with the page number to drop, and the page-table base. It hands the block fault events, each carrying a 3-bit type code and the faulting address.

Halting is a handshake. After a halt request, the hold output rises at once, but the block reports itself halted only once the datapath signals that outstanding traffic has drained. Any fault that arrives while the MMU is on skips the handshake and halts the MMU directly. In both cases the MMU stays halted until software writes the run code again. Each fault sets its own interrupt status bit, and the interrupt line is the OR of all status bits. The faulting address is steered by fault type into one of four capture registers: page-fault, read-side, write-side or bus-error.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset, xlat_en, xlat_hold, irq, both flush strobes and flt_primary are 0, and every register reads 0.
- R2: A write to the control register (0x000) of exactly 0x5 turns translation on (xlat_en=1, hold=0, reads 0x5), and exactly 0x0 turns it off (reads 0x0). Any other value except 0x7 leaves the mode unchanged. A halted MMU reads 0x7.
- R3: Writing 0x7 to the control register while off or running raises xlat_hold and xlat_en from the next cycle. Status register (0x008) bit 0 stays 0 until drain_done is seen high at a clock edge, and it reads 1 from the following cycle.
- R4: Writing 0x5 while halting or halted drops xlat_hold and clears status bit 0 on the next cycle, unless a fault arrives in the same cycle.
- R5: Writing the flush-all register (0x00C) with bit 0 set gives a one-cycle flush_all_p in the cycle after the write. Bit 0 clear gives no strobe.
- R6: Writing the flush-entry register (0x010) with bit 0 set gives a one-cycle flush_ent_p in the cycle after the write, with flush_ent_page equal to write data bits [31:12]. Bit 0 clear gives no strobe, and the page output is unchanged.
- R7: The page-table base register (0x014) stores and reads back the full word, drives pt_base, and also triggers a one-cycle flush_all_p in the cycle after the write.
- R8: A fault event with type t sets interrupt status (0x018) bit t in the next cycle. The bit order is 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write protection. irq is the OR of the status bits.
- R9: The fault address is captured by type: type 0 into 0x024, types 1, 4 and 5 into 0x02C, types 2, 6 and 7 into 0x028, and type 3 into 0x030.
- R10: A fault while the MMU is not off moves it straight to halted: xlat_hold=1, status bit 0 =1, control reads 0x7. This takes priority over a same-cycle control write.
- R11: Writing the interrupt-clear register (0x01C) with bit n set clears status bit n. Zero bits have no effect, a new fault on bit n in the same cycle wins, and the register reads 0.
- R12: flt_primary gives the index of the lowest set interrupt status bit, or 0 when none is set.
- R13: The config register (0x004) stores and reads back the full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational on address |
| drain_done | input | 1 | Datapath has no outstanding traffic |
| flt_valid | input | 1 | Fault event strobe |
| flt_type | input | 3 | Fault type code |
| flt_addr | input | DATA_W (32) | Faulting address |
| xlat_en | output | 1 | Translation enabled |
| xlat_hold | output | 1 | Stall new translation traffic |
| flush_all_p | output | 1 | Invalidate whole TLB strobe |
| flush_ent_p | output | 1 | Invalidate one page strobe |
| flush_ent_page | output | DATA_W-PAGE_SHIFT (20) | Page number to invalidate |
| pt_base | output | DATA_W (32) | Page-table base |
| irq | output | 1 | Fault interrupt |
| flt_primary | output | 3 | Lowest pending fault type |

## Verification
Every state, strobe and status change becomes visible in the cycle after the clock edge that sampled the write, fault or drain event. Halted status therefore trails the drain edge by one cycle, and a flush strobe lasts exactly that one cycle. Read data is combinational, so a read is checked in the same cycle its address is presented. The bench drives inputs on the falling edge and steps a behavioural model on the same rising edge as the design. It compares every registered output at the next falling edge and samples read data shortly after the address settles, so each result is checked in the exact cycle it is due.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
   // register byte offsets (software-visible map)
   localparam int unsigned REG_CTRL  = 'h000;
   localparam int unsigned REG_CFG   = 'h004;
   localparam int unsigned REG_STAT  = 'h008;
   localparam int unsigned REG_FLALL = 'h00C;
   localparam int unsigned REG_FLENT = 'h010;
   localparam int unsigned REG_PTB   = 'h014;
   localparam int unsigned REG_ISTAT = 'h018;
   localparam int unsigned REG_ICLR  = 'h01C;
   localparam int unsigned REG_PFA   = 'h024;
   localparam int unsigned REG_WFA   = 'h028;
   localparam int unsigned REG_RFA   = 'h02C;
   localparam int unsigned REG_BEA   = 'h030;

   // control codes
   localparam int unsigned CODE_OFF  = 'h0;
   localparam int unsigned CODE_RUN  = 'h5;
   localparam int unsigned CODE_HALT = 'h7;

   localparam int unsigned FLT_N = 8;
   localparam int unsigned FLT_W = $clog2(FLT_N);

   typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_HALTING, ST_HALTED} ctl_st_e;
   typedef enum logic [1:0] {CAP_PAGE, CAP_RD, CAP_WR, CAP_BUS} cap_sel_e;

   // which address register a fault type reports through
   function automatic cap_sel_e cap_route(input logic [FLT_W-1:0] t);
      case (t)
         3'd0:             return CAP_PAGE;
         3'd3:             return CAP_BUS;
         3'd1, 3'd4, 3'd5: return CAP_RD;
         default:          return CAP_WR;
      endcase
   endfunction
endpackage

// File: rtl/mmu_ctl_fsm.sv
module mmu_ctl_fsm
   import mmu_ctl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_code,
   input  logic              drain_done,
   input  logic              flt_hit,
   output ctl_st_e           state
);
   ctl_st_e nxt;

   always_comb begin
      nxt = state;
      if (state == ST_HALTING && drain_done)
         nxt = ST_HALTED;
      if (ctl_wr) begin
         if (ctl_code == DATA_W'(CODE_RUN))
            nxt = ST_RUN;
         else if (ctl_code == DATA_W'(CODE_OFF))
            nxt = ST_OFF;
         else if (ctl_code == DATA_W'(CODE_HALT) &&
                  (state == ST_OFF || state == ST_RUN))
            nxt = ST_HALTING;
      end
      // a fault halts at once and overrides software
      if (flt_hit && state != ST_OFF)
         nxt = ST_HALTED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OFF;
      else        state <= nxt;
   end
endmodule

// File: rtl/mmu_flt_log.sv
module mmu_flt_log
   import mmu_ctl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_valid,
   input  logic [FLT_W-1:0]  flt_type,
   input  logic [DATA_W-1:0] flt_addr,
   input  logic              clr_wr,
   input  logic [FLT_N-1:0]  clr_mask,
   output logic [FLT_N-1:0]  ist,
   output logic [DATA_W-1:0] pf_addr,
   output logic [DATA_W-1:0] rd_addr,
   output logic [DATA_W-1:0] wr_addr,
   output logic [DATA_W-1:0] be_addr,
   output logic              irq,
   output logic [FLT_W-1:0]  primary
);
   cap_sel_e route;
   assign route = cap_route(flt_type);

   for (genvar i = 0; i < FLT_N; i++) begin : g_bit
      logic set_i;
      assign set_i = flt_valid && (flt_type == FLT_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    ist[i] <= 1'b0;
         else if (set_i)                ist[i] <= 1'b1;
         else if (clr_wr && clr_mask[i]) ist[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_addr <= '0;
         rd_addr <= '0;
         wr_addr <= '0;
         be_addr <= '0;
      end else if (flt_valid) begin
         case (route)
            CAP_PAGE: pf_addr <= flt_addr;
            CAP_RD:   rd_addr <= flt_addr;
            CAP_WR:   wr_addr <= flt_addr;
            default:  be_addr <= flt_addr;
         endcase
      end
   end

   always_comb begin
      primary = '0;
      for (int i = FLT_N - 1; i >= 0; i--)
         if (ist[i]) primary = FLT_W'(i);
   end

   assign irq = |ist;
endmodule

// File: rtl/mmu_cmd_pulse.sv
module mmu_cmd_pulse #(
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter bit AUTO_FLUSH = 1'b1,
   localparam int PAGE_W    = DATA_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flall_wr,
   input  logic              flent_wr,
   input  logic              ptb_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              flush_all_p,
   output logic              flush_ent_p,
   output logic [PAGE_W-1:0] flush_ent_page
);
   logic all_req;
   logic ent_req;

   if (AUTO_FLUSH) begin : g_auto
      assign all_req = (flall_wr && wdata[0]) || ptb_wr;
   end else begin : g_manual
      assign all_req = flall_wr && wdata[0];
   end

   assign ent_req = flent_wr && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_all_p    <= 1'b0;
         flush_ent_p    <= 1'b0;
         flush_ent_page <= '0;
      end else begin
         flush_all_p <= all_req;
         flush_ent_p <= ent_req;
         if (ent_req) flush_ent_page <= wdata[DATA_W-1:PAGE_SHIFT];
      end
   end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
   import mmu_ctl_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter bit AUTO_FLUSH = 1'b1,
   localparam int PAGE_W    = DATA_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              drain_done,
   input  logic              flt_valid,
   input  logic [2:0]        flt_type,
   input  logic [DATA_W-1:0] flt_addr,
   output logic              xlat_en,
   output logic              xlat_hold,
   output logic              flush_all_p,
   output logic              flush_ent_p,
   output logic [PAGE_W-1:0] flush_ent_page,
   output logic [DATA_W-1:0] pt_base,
   output logic              irq,
   output logic [2:0]        flt_primary
);
   if (DATA_W != 32) begin : g_bad_data
      $error("mmu_ctl_regs: DATA_W must be 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("mmu_ctl_regs: ADDR_W too small for register map");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= DATA_W) begin : g_bad_page
      $error("mmu_ctl_regs: PAGE_SHIFT out of range");
   end

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(REG_CFG);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_STAT);
   localparam logic [ADDR_W-1:0] A_FLALL = ADDR_W'(REG_FLALL);
   localparam logic [ADDR_W-1:0] A_FLENT = ADDR_W'(REG_FLENT);
   localparam logic [ADDR_W-1:0] A_PTB   = ADDR_W'(REG_PTB);
   localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(REG_ISTAT);
   localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(REG_ICLR);
   localparam logic [ADDR_W-1:0] A_PFA   = ADDR_W'(REG_PFA);
   localparam logic [ADDR_W-1:0] A_WFA   = ADDR_W'(REG_WFA);
   localparam logic [ADDR_W-1:0] A_RFA   = ADDR_W'(REG_RFA);
   localparam logic [ADDR_W-1:0] A_BEA   = ADDR_W'(REG_BEA);

   logic wr_en;
   assign wr_en = bus_sel && bus_wr;

   // control state
   ctl_st_e state;
   mmu_ctl_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (wr_en && bus_addr == A_CTRL),
      .ctl_code   (bus_wdata),
      .drain_done (drain_done),
      .flt_hit    (flt_valid),
      .state      (state)
   );

   assign xlat_en   = (state != ST_OFF);
   assign xlat_hold = (state == ST_HALTING) || (state == ST_HALTED);

   // fault status and address capture
   logic [FLT_N-1:0]  ist;
   logic [DATA_W-1:0] pf_addr, rd_addr, wr_addr, be_addr;
   mmu_flt_log #(.DATA_W(DATA_W)) u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .flt_valid (flt_valid),
      .flt_type  (flt_type),
      .flt_addr  (flt_addr),
      .clr_wr    (wr_en && bus_addr == A_ICLR),
      .clr_mask  (bus_wdata[FLT_N-1:0]),
      .ist       (ist),
      .pf_addr   (pf_addr),
      .rd_addr   (rd_addr),
      .wr_addr   (wr_addr),
      .be_addr   (be_addr),
      .irq       (irq),
      .primary   (flt_primary)
   );

   // flush strobes
   mmu_cmd_pulse #(
      .DATA_W     (DATA_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .AUTO_FLUSH (AUTO_FLUSH)
   ) u_cmd (
      .clk            (clk),
      .rst_n          (rst_n),
      .flall_wr       (wr_en && bus_addr == A_FLALL),
      .flent_wr       (wr_en && bus_addr == A_FLENT),
      .ptb_wr         (wr_en && bus_addr == A_PTB),
      .wdata          (bus_wdata),
      .flush_all_p    (flush_all_p),
      .flush_ent_p    (flush_ent_p),
      .flush_ent_page (flush_ent_page)
   );

   // plain storage registers
   logic [DATA_W-1:0] cfg_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         pt_base <= '0;
      end else if (wr_en) begin
         if (bus_addr == A_CFG) cfg_q   <= bus_wdata;
         if (bus_addr == A_PTB) pt_base <= bus_wdata;
      end
   end

   // read mux
   logic [DATA_W-1:0] ctl_rd;
   always_comb begin
      case (state)
         ST_OFF:  ctl_rd = DATA_W'(CODE_OFF);
         ST_RUN:  ctl_rd = DATA_W'(CODE_RUN);
         default: ctl_rd = DATA_W'(CODE_HALT);
      endcase
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            A_CTRL:  bus_rdata = ctl_rd;
            A_CFG:   bus_rdata = cfg_q;
            A_STAT:  bus_rdata = DATA_W'(state == ST_HALTED);
            A_PTB:   bus_rdata = pt_base;
            A_ISTAT: bus_rdata = DATA_W'(ist);
            A_PFA:   bus_rdata = pf_addr;
            A_WFA:   bus_rdata = wr_addr;
            A_RFA:   bus_rdata = rd_addr;
            A_BEA:   bus_rdata = be_addr;
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk
   import mmu_ctl_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12,
   localparam int PAGE_W    = DATA_W - PAGE_SHIFT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              flt_valid,
   input logic              xlat_en,
   input logic              xlat_hold,
   input logic              flush_all_p,
   input logic              flush_ent_p,
   input logic [PAGE_W-1:0] flush_ent_page,
   input logic              irq,
   input logic [2:0]        flt_primary
);
   logic w_ctrl, w_flall, w_flent;
   assign w_ctrl  = bus_sel && bus_wr && bus_addr == ADDR_W'(REG_CTRL);
   assign w_flall = bus_sel && bus_wr && bus_addr == ADDR_W'(REG_FLALL);
   assign w_flent = bus_sel && bus_wr && bus_addr == ADDR_W'(REG_FLENT);

   a_r2_off_write: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctrl && bus_wdata == DATA_W'(CODE_OFF) && !flt_valid) |=> !xlat_en);

   a_r4_run_write: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctrl && bus_wdata == DATA_W'(CODE_RUN) && !flt_valid) |=> (xlat_en && !xlat_hold));

   a_r3_hold_implies_en: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_hold |-> xlat_en);

   a_r10_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && xlat_en) |=> xlat_hold);

   a_r8_fault_irq: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |=> irq);

   a_r5_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
      (w_flall && bus_wdata[0]) |=> flush_all_p);

   a_r6_flush_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (w_flent && bus_wdata[0]) |=>
         (flush_ent_p && flush_ent_page == $past(bus_wdata[DATA_W-1:PAGE_SHIFT])));

   a_r12_idle_primary: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (flt_primary == 3'd0));
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_sel        (bus_sel),
   .bus_wr         (bus_wr),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .flt_valid      (flt_valid),
   .xlat_en        (xlat_en),
   .xlat_hold      (xlat_hold),
   .flush_all_p    (flush_all_p),
   .flush_ent_p    (flush_ent_p),
   .flush_ent_page (flush_ent_page),
   .irq            (irq),
   .flt_primary    (flt_primary)
);

// File: tb/mmu_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module mmu_ctl_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        drain_done = 1'b0;
   logic        flt_valid = 1'b0;
   logic [2:0]  flt_type = '0;
   logic [31:0] flt_addr = '0;
   logic        xlat_en, xlat_hold, flush_all_p, flush_ent_p, irq;
   logic [19:0] flush_ent_page;
   logic [31:0] pt_base;
   logic [2:0]  flt_primary;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mmu_ctl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .drain_done(drain_done), .flt_valid(flt_valid), .flt_type(flt_type),
      .flt_addr(flt_addr), .xlat_en(xlat_en), .xlat_hold(xlat_hold),
      .flush_all_p(flush_all_p), .flush_ent_p(flush_ent_p),
      .flush_ent_page(flush_ent_page), .pt_base(pt_base), .irq(irq),
      .flt_primary(flt_primary)
   );

   // ---------------- behavioural reference model ----------------
   int          m_mode;  // 0 off, 1 run, 2 halting, 3 halted
   logic [31:0] m_cfg, m_ptb, m_pfa, m_rfa, m_wfa, m_bea;
   logic [7:0]  m_ist;
   logic        m_fa, m_fe;
   logic [19:0] m_page;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_cfg = 0; m_ptb = 0; m_ist = 0;
         m_pfa = 0; m_rfa = 0; m_wfa = 0; m_bea = 0;
         m_fa = 0; m_fe = 0; m_page = 0;
      end else begin
         bit wr;
         int nm;
         logic [7:0] clr, setm;
         wr = bus_sel && bus_wr;
         nm = m_mode;
         if (m_mode == 2 && drain_done) nm = 3;
         if (wr && bus_addr == 8'h00) begin
            if (bus_wdata == 32'h5) nm = 1;
            else if (bus_wdata == 32'h0) nm = 0;
            else if (bus_wdata == 32'h7 && m_mode <= 1) nm = 2;
         end
         if (flt_valid && m_mode != 0) nm = 3;
         clr  = (wr && bus_addr == 8'h1C) ? bus_wdata[7:0] : 8'h0;
         setm = flt_valid ? (8'h1 << flt_type) : 8'h0;
         m_ist = (m_ist & ~clr) | setm;
         if (flt_valid) begin
            if (flt_type == 0) m_pfa = flt_addr;
            else if (flt_type == 3) m_bea = flt_addr;
            else if (flt_type == 1 || flt_type == 4 || flt_type == 5) m_rfa = flt_addr;
            else m_wfa = flt_addr;
         end
         if (wr && bus_addr == 8'h04) m_cfg = bus_wdata;
         if (wr && bus_addr == 8'h14) m_ptb = bus_wdata;
         m_fa = (wr && bus_addr == 8'h0C && bus_wdata[0]) || (wr && bus_addr == 8'h14);
         m_fe = wr && bus_addr == 8'h10 && bus_wdata[0];
         if (m_fe) m_page = bus_wdata[31:12];
         m_mode = nm;
      end
   end

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00: return (m_mode == 0) ? 32'h0 : (m_mode == 1) ? 32'h5 : 32'h7;
         8'h04: return m_cfg;
         8'h08: return {31'b0, m_mode == 3};
         8'h14: return m_ptb;
         8'h18: return {24'b0, m_ist};
         8'h24: return m_pfa;
         8'h28: return m_wfa;
         8'h2C: return m_rfa;
         8'h30: return m_bea;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [2:0] exp_primary();
      for (int i = 0; i < 8; i++) if (m_ist[i]) return 3'(i);
      return 3'd0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison of registered outputs
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R2 xlat_en", 32'(xlat_en), 32'(m_mode != 0));
         check("R3 xlat_hold", 32'(xlat_hold), 32'(m_mode >= 2));
         check("R5 flush_all_p", 32'(flush_all_p), 32'(m_fa));
         check("R6 flush_ent_p", 32'(flush_ent_p), 32'(m_fe));
         check("R6 flush_ent_page", 32'(flush_ent_page), 32'(m_page));
         check("R7 pt_base", pt_base, m_ptb);
         check("R8 irq", 32'(irq), 32'(|m_ist));
         check("R12 flt_primary", 32'(flt_primary), 32'(exp_primary()));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1;
      check(tag, bus_rdata, exp_read(a));
      bus_sel = 0;
   endtask

   task automatic fault(input logic [2:0] t, input logic [31:0] a);
      @(negedge clk);
      flt_valid = 1; flt_type = t; flt_addr = a;
      @(negedge clk);
      flt_valid = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(1);
      // R1: reset state
      rd(8'h00, "R1 ctrl reset");
      rd(8'h08, "R1 status reset");
      rd(8'h18, "R1 int status reset");
      rd(8'h30, "R1 bus err addr reset");
      check("R1 irq reset", 32'(irq), 32'h0);
      // R2: enable, bad code, disable
      wr(8'h00, 32'h5); rd(8'h00, "R2 ctrl run");
      wr(8'h00, 32'h3); rd(8'h00, "R2 ignored code");
      wr(8'h00, 32'h105); rd(8'h00, "R2 wide code ignored");
      // R13 config
      wr(8'h04, 32'hA5A5_1234); rd(8'h04, "R13 config");
      // R5 flush all
      wr(8'h0C, 32'h1); wr(8'h0C, 32'h0);
      // R6 flush entry
      wr(8'h10, 32'hDEAD_B001); wr(8'h10, 32'h1234_5000);
      rd(8'h10, "R6 flush reg reads 0");
      // R7 page table base with automatic flush
      wr(8'h14, 32'h8000_4000); rd(8'h14, "R7 ptb readback");
      // R3 halt handshake
      wr(8'h00, 32'h7);
      rd(8'h08, "R3 not yet halted");
      idle(3);
      rd(8'h08, "R3 still halting");
      rd(8'h00, "R3 ctrl reads halt code");
      @(negedge clk); drain_done = 1;
      @(negedge clk); drain_done = 0;
      rd(8'h08, "R3 halted after drain");
      // R4 resume
      wr(8'h00, 32'h5);
      rd(8'h08, "R4 status cleared");
      // R8/R9: every fault type
      for (int t = 0; t < 8; t++) begin
         fault(3'(t), 32'h1000_0000 + 32'(t) * 32'h111);
         rd(8'h18, "R8 int status");
         rd(8'h00, "R10 ctrl after fault");
         rd(8'h08, "R10 status after fault");
         rd(8'h24, "R9 page fault addr");
         rd(8'h28, "R9 write fault addr");
         rd(8'h2C, "R9 read fault addr");
         rd(8'h30, "R9 bus err addr");
         wr(8'h00, 32'h5);
      end
      // R11/R12: partial clears and priority
      wr(8'h1C, 32'h0000_0000); rd(8'h18, "R11 zero clear no effect");
      wr(8'h1C, 32'h0000_0005); rd(8'h18, "R11 clear bits 0 and 2");
      rd(8'h1C, "R11 clear reg reads 0");
      wr(8'h1C, 32'h0000_00F0); rd(8'h18, "R12 lowest pending");
      // R11: fault and clear of the same bit together -> set wins
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 32'h2;
      flt_valid = 1; flt_type = 3'd1; flt_addr = 32'hCAFE_0000;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; flt_valid = 0;
      rd(8'h18, "R11 set beats clear");
      // R10: fault wins over same-cycle run write
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h5;
      flt_valid = 1; flt_type = 3'd7; flt_addr = 32'hBEEF_0000;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; flt_valid = 0;
      rd(8'h08, "R10 fault beats run write");
      rd(8'h28, "R9 write fault addr late");
      // R2 disable, then fault while off leaves mode off
      wr(8'h00, 32'h0); rd(8'h00, "R2 ctrl off");
      fault(3'd4, 32'h0BAD_0000);
      rd(8'h00, "R10 fault while off");
      rd(8'h2C, "R9 read fault addr while off");
      wr(8'h1C, 32'hFF); rd(8'h18, "R11 clear all");
      idle(2);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule